// File: doc/BRIEF.md
# Interrupt Control Instruction Unit

This unit sits beside the execute stage of a small 32-bit core. It handles the core's interrupt-control instructions. A few codes in the custom-0 opcode space are routed to it. Those codes move data between general registers and four private context registers, called q-registers. They also exchange the interrupt mask, sleep until a request arrives, load the external timer, and return from a handler. The unit also keeps a sticky pending bit for every interrupt source. It decides when to enter a handler and redirects the program counter there. The return address and the bits that caused entry are parked in q-registers, so no stack is needed.

Instructions arrive on a valid/ready pair. The unit takes a word only in a cycle where `ins_valid` and `ins_ready` are both high. The core must hold the word and its `rs1_val` steady while `ins_ready` is low. `ins_ready` drops in these cases: while a wait instruction sleeps, in the cycle the unit enters a handler, and forever after a halt. Results appear one cycle after acceptance as single-cycle pulses. These are the register write-back, the PC redirect, the illegal-instruction flag and the timer load. They carry no back-pressure.

Instruction fields: funct7 [31:25], rs2 [24:20], rs1 [19:15], funct3 [14:12], rd [11:7], opcode [6:0].

Fixed interrupt source numbers:
- bit 0 is the timer, ORed with `irq_req[0]`;
- bit 1 is the illegal-instruction event;
- bit 2 is the bus error.

Top module: `qirq_unit`

## Requirements
- R1: A word is handled only when opcode [6:0] is 0001011. Any other opcode is accepted with no effect on any output or state. With funct3 = 000, funct7 picks the operation: 0 getq, 1 setq, 2 retirq, 3 maskirq, 4 waitirq, 5 timer.
- R2: setq writes `rs1_val` into the q-register numbered by rd [8:7]. getq returns the q-register numbered by rs1 [16:15] on `rd_val`, one cycle after acceptance. All q-registers read zero after reset.
- R3: maskirq returns the previous mask and loads `rs1_val` as the new mask. A 1 bit disables that source. The mask is all ones after reset.
- R4: A pending bit is set by its request and stays set until that interrupt is taken. A masked pending bit never causes handler entry.
- R5: Entry happens in a cycle where all of these hold: a pending bit is unmasked, interrupts are enabled, and no instruction is being accepted (`ins_ready` low). In the next cycle the unit does all of the following:
  - it pulses `redir_valid` with `redir_pc` = HANDLER_PC and writes no register;
  - q0 holds `cur_pc` and q1 holds the taken bits;
  - those pending bits are cleared;
  - interrupts are disabled until a retirq.
- R6: retirq redirects to the value in q0 and re-enables interrupts. A still-pending unmasked source is then entered in the cycle right after the redirect.
- R7: If any pending bit is set, waitirq returns the whole pending vector at once. Otherwise it holds `ins_ready` low. It then writes the pending vector one cycle after the first pending bit appears. waitirq does not clear pending bits.
- R8: timer pulses `timer_ld` with `timer_ld_val` = `rs1_val`. It returns `timer_cur`, the counter value before the load.
- R9: A custom-0 word is illegal when funct3 is not 000 or funct7 is greater than 5. An illegal word writes no register, pulses `ill_flag` and sets pending bit 1.
- R10: An illegal event (decoded, or on `ill_in`) while mask bit 1 is set raises `halt` permanently. So does `bus_err` while mask bit 2 is set.
- R11: A result with rd = x0 never pulses `rd_we`.
- R12: `ins_ready` is low while a waitirq sleeps, in an entry cycle and whenever `halt` is high. A word offered while `ins_ready` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Unit can take a word this cycle |
| ins_word | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of the rs1 general register |
| cur_pc | input | XLEN | PC to resume at after a handler |
| irq_req | input | NIRQ | Interrupt request lines |
| ill_in | input | 1 | Illegal instruction seen elsewhere in the core |
| bus_err | input | 1 | Bus error strobe |
| timer_irq | input | 1 | Timer expiry request |
| timer_cur | input | XLEN | Current timer count |
| rd_we | output | 1 | Register write-back pulse |
| rd_idx | output | 5 | Destination register number |
| rd_val | output | XLEN | Write-back value |
| redir_valid | output | 1 | PC redirect pulse |
| redir_pc | output | XLEN | Redirect target |
| ill_flag | output | 1 | Illegal custom word taken |
| timer_ld | output | 1 | Timer load pulse |
| timer_ld_val | output | XLEN | New timer count |
| halt | output | 1 | Core halted for good |

## Verification
The bench probes these corner cases:
- Requests that arrive while masked or while interrupts are off must not cause entry. A design that ignores the mask or the enable redirects early.
- An interrupt that is pending when retirq executes must be re-entered straight away. A design that loses pending bits, or that fails to re-enable, sits idle instead.
- waitirq is tried both with a pending bit already set and with an empty pending vector that fills later. Getting this wrong shows up as a hang, a stale zero result, or a write with the wrong register number.
- An illegal word with its source unmasked must only set a pending bit. A bus error with its source masked must freeze the unit. After that freeze, a getq must return nothing.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

  localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

  localparam int SRC_TIMER   = 0;
  localparam int SRC_ILLEGAL = 1;
  localparam int SRC_BUSERR  = 2;

  typedef enum logic [2:0] {
    OP_GETQ    = 3'd0,
    OP_SETQ    = 3'd1,
    OP_RETIRQ  = 3'd2,
    OP_MASKIRQ = 3'd3,
    OP_WAITIRQ = 3'd4,
    OP_TIMER   = 3'd5,
    OP_NONE    = 3'd6,
    OP_ILL     = 3'd7
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [4:0] rd;
    logic [4:0] rs1f;
  } dec_t;

endpackage

// File: rtl/qirq_decode.sv
module qirq_decode
  import qirq_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec
);

  logic [6:0] f7;
  logic [2:0] f3;
  logic [6:0] opc;
  logic       unused_rs2;

  assign f7  = word[31:25];
  assign f3  = word[14:12];
  assign opc = word[6:0];
  assign unused_rs2 = ^word[24:20];

  always_comb begin
    dec.rd   = word[11:7];
    dec.rs1f = word[19:15];
    if (opc != OPC_CUSTOM0) begin
      dec.op = OP_NONE;
    end else if (f3 != 3'd0 || f7 > 7'd5) begin
      dec.op = OP_ILL;
    end else begin
      dec.op = op_e'(f7[2:0]);
    end
  end

endmodule

// File: rtl/qirq_qfile.sv
module qirq_qfile #(
  parameter int XLEN = 32,
  parameter int NQ   = 4,
  localparam int QW  = $clog2(NQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [QW-1:0]   set_sel,
  input  logic [XLEN-1:0] set_val,
  input  logic            ent_en,
  input  logic [XLEN-1:0] ent_pc,
  input  logic [XLEN-1:0] ent_bits,
  input  logic [QW-1:0]   rd_sel,
  output logic [XLEN-1:0] rd_val,
  output logic [XLEN-1:0] q0_val
);

  logic [NQ-1:0][XLEN-1:0] qflat;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic [XLEN-1:0] qr;
    logic            hit;
    assign hit = set_en && (set_sel == QW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        qr <= '0;
      end else if (ent_en && i == 0) begin
        qr <= ent_pc;
      end else if (ent_en && i == 1) begin
        qr <= ent_bits;
      end else if (hit) begin
        qr <= set_val;
      end
    end
    assign qflat[i] = qr;
  end

  assign rd_val = qflat[rd_sel];
  assign q0_val = qflat[0];

endmodule

// File: rtl/qirq_srcstate.sv
module qirq_srcstate #(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] req,
  input  logic [NIRQ-1:0] take_bits,
  input  logic            mask_we,
  input  logic [NIRQ-1:0] mask_wval,
  output logic [NIRQ-1:0] mask,
  output logic [NIRQ-1:0] pend
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (mask_we) begin
      mask <= mask_wval;
    end
  end

  for (genvar b = 0; b < NIRQ; b++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[b] <= 1'b0;
      end else if (req[b]) begin
        pend[b] <= 1'b1;
      end else if (take_bits[b]) begin
        pend[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/qirq_unit.sv
module qirq_unit
  import qirq_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NIRQ       = 32,
  parameter int              NQ         = 4,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [31:0]     ins_word,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            ill_in,
  input  logic            bus_err,
  input  logic            timer_irq,
  input  logic [XLEN-1:0] timer_cur,
  output logic            rd_we,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] rd_val,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            ill_flag,
  output logic            timer_ld,
  output logic [XLEN-1:0] timer_ld_val,
  output logic            halt
);

  localparam int QW = $clog2(NQ);

  dec_t            dec;
  op_e             op;
  logic            fire;
  logic            irq_take;
  logic            wake;
  logic            waiting_q;
  logic            halt_q;
  logic            irq_en_q;
  logic [4:0]      wait_rd_q;
  logic [NIRQ-1:0] mask;
  logic [NIRQ-1:0] pend;
  logic [NIRQ-1:0] live;
  logic [NIRQ-1:0] src;
  logic [NIRQ-1:0] take_bits;
  logic [XLEN-1:0] q_rd;
  logic [XLEN-1:0] q0;
  logic            ill_evt;
  logic            halt_set;
  logic            any_pend;
  logic            unused_rs1f;

  qirq_decode u_dec (
    .word (ins_word),
    .dec  (dec)
  );

  assign unused_rs1f = ^dec.rs1f[4:QW];

  assign live      = pend & ~mask;
  assign any_pend  = |pend;
  assign irq_take  = !halt_q && !waiting_q && irq_en_q && (|live);
  assign ins_ready = !halt_q && !waiting_q && !irq_take;
  assign fire      = ins_valid && ins_ready;
  assign op        = fire ? dec.op : OP_NONE;
  assign wake      = waiting_q && any_pend && !halt_q;
  assign take_bits = irq_take ? live : '0;

  assign ill_evt  = (op == OP_ILL) || ill_in;
  assign halt_set = (ill_evt && mask[SRC_ILLEGAL]) || (bus_err && mask[SRC_BUSERR]);

  always_comb begin
    src = irq_req;
    src[SRC_TIMER]   = irq_req[SRC_TIMER] | timer_irq;
    src[SRC_ILLEGAL] = irq_req[SRC_ILLEGAL] | ill_evt;
    src[SRC_BUSERR]  = irq_req[SRC_BUSERR] | bus_err;
  end

  qirq_srcstate #(.NIRQ(NIRQ)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (src),
    .take_bits (take_bits),
    .mask_we   (op == OP_MASKIRQ),
    .mask_wval (rs1_val[NIRQ-1:0]),
    .mask      (mask),
    .pend      (pend)
  );

  qirq_qfile #(.XLEN(XLEN), .NQ(NQ)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (op == OP_SETQ),
    .set_sel  (dec.rd[QW-1:0]),
    .set_val  (rs1_val),
    .ent_en   (irq_take),
    .ent_pc   (cur_pc),
    .ent_bits (XLEN'(live)),
    .rd_sel   (dec.rs1f[QW-1:0]),
    .rd_val   (q_rd),
    .q0_val   (q0)
  );

  // write-back selection
  logic            wb_en;
  logic [4:0]      wb_idx;
  logic [XLEN-1:0] wb_val;

  always_comb begin
    wb_en  = 1'b0;
    wb_idx = dec.rd;
    wb_val = '0;
    unique case (op)
      OP_GETQ:    begin wb_en = 1'b1; wb_val = q_rd; end
      OP_MASKIRQ: begin wb_en = 1'b1; wb_val = XLEN'(mask); end
      OP_TIMER:   begin wb_en = 1'b1; wb_val = timer_cur; end
      OP_WAITIRQ: begin wb_en = any_pend; wb_val = XLEN'(pend); end
      default:    ;
    endcase
    if (wake) begin
      wb_en  = 1'b1;
      wb_idx = wait_rd_q;
      wb_val = XLEN'(pend);
    end
    if (wb_idx == 5'd0) begin
      wb_en = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
      halt_q    <= 1'b0;
      irq_en_q  <= 1'b1;
      wait_rd_q <= 5'd0;
    end else begin
      if (halt_set) begin
        halt_q <= 1'b1;
      end
      if (op == OP_WAITIRQ && !any_pend) begin
        waiting_q <= 1'b1;
        wait_rd_q <= dec.rd;
      end else if (wake) begin
        waiting_q <= 1'b0;
      end
      if (irq_take) begin
        irq_en_q <= 1'b0;
      end else if (op == OP_RETIRQ) begin
        irq_en_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_we        <= 1'b0;
      rd_idx       <= 5'd0;
      rd_val       <= '0;
      redir_valid  <= 1'b0;
      redir_pc     <= '0;
      ill_flag     <= 1'b0;
      timer_ld     <= 1'b0;
      timer_ld_val <= '0;
    end else begin
      rd_we    <= wb_en;
      ill_flag <= (op == OP_ILL);
      timer_ld <= (op == OP_TIMER);
      if (wb_en) begin
        rd_idx <= wb_idx;
        rd_val <= wb_val;
      end
      if (op == OP_TIMER) begin
        timer_ld_val <= rs1_val;
      end
      redir_valid <= irq_take || (op == OP_RETIRQ);
      if (irq_take) begin
        redir_pc <= HANDLER_PC;
      end else if (op == OP_RETIRQ) begin
        redir_pc <= q0;
      end
    end
  end

  assign halt = halt_q;

endmodule

// File: rtl/qirq_unit_chk.sv
module qirq_unit_chk #(
  parameter int              XLEN       = 32,
  parameter int              NIRQ       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0010
) (
  input logic            clk,
  input logic            rst_n,
  input logic            halt,
  input logic            ins_ready,
  input logic            rd_we,
  input logic [4:0]      rd_idx,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_pc,
  input logic            irq_take,
  input logic            waiting,
  input logic [NIRQ-1:0] pend
);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  assert_halt_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !ins_ready);

  assert_x0_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_idx != 5'd0));

  assert_entry_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (redir_valid && redir_pc == HANDLER_PC));

  assert_redir_rd_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_valid && rd_we));

  assert_wait_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !halt && pend != '0) |=> !waiting);

endmodule

bind qirq_unit qirq_unit_chk #(.XLEN(XLEN), .NIRQ(NIRQ), .HANDLER_PC(HANDLER_PC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt        (halt),
  .ins_ready   (ins_ready),
  .rd_we       (rd_we),
  .rd_idx      (rd_idx),
  .redir_valid (redir_valid),
  .redir_pc    (redir_pc),
  .irq_take    (irq_take),
  .waiting     (waiting_q),
  .pend        (pend)
);

// File: tb/qirq_unit_tb_top.sv
module qirq_unit_tb_top;

  localparam logic [31:0] HPC  = 32'h0000_0010;
  localparam logic [31:0] RPC  = 32'h0000_0400;
  localparam logic [31:0] TCUR = 32'h0000_1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [31:0] ins_word = '0;
  logic [31:0] rs1_val = '0;
  logic [31:0] cur_pc = RPC;
  logic [31:0] irq_req = '0;
  logic        ill_in = 1'b0;
  logic        bus_err = 1'b0;
  logic        timer_irq = 1'b0;
  logic [31:0] timer_cur = TCUR;
  logic        rd_we;
  logic [4:0]  rd_idx;
  logic [31:0] rd_val;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic        ill_flag;
  logic        timer_ld;
  logic [31:0] timer_ld_val;
  logic        halt;

  always #10 clk = ~clk;

  qirq_unit #(.HANDLER_PC(HPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .rs1_val(rs1_val), .cur_pc(cur_pc), .irq_req(irq_req),
    .ill_in(ill_in), .bus_err(bus_err), .timer_irq(timer_irq), .timer_cur(timer_cur),
    .rd_we(rd_we), .rd_idx(rd_idx), .rd_val(rd_val), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .ill_flag(ill_flag), .timer_ld(timer_ld),
    .timer_ld_val(timer_ld_val), .halt(halt)
  );

  int  tests = 0;
  int  fails = 0;
  logic done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [6:0] f7, input logic [4:0] rs,
                                     input logic [2:0] f3, input logic [4:0] rd);
    return {f7, 5'd0, rs, f3, rd, 7'b0001011};
  endfunction

  // drive at a falling edge, taken at the rising edge, results seen at the next falling edge
  task automatic issue(input logic [31:0] w, input logic [31:0] rs);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_word  = w;
    rs1_val   = rs;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic pulse_irq(input int b);
    @(negedge clk);
    irq_req[b] = 1'b1;
    @(negedge clk);
    irq_req[b] = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] w;
    logic [31:0] rs;
    logic        we;
    logic [4:0]  rd;
    logic [31:0] val;
    logic        tld;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{{7'd1,5'd0,5'd0,3'd0,5'd2,7'h0B},  32'hA5A5_0001, 1'b0, 5'd0,  32'h0,          1'b0},
    '{{7'd0,5'd0,5'd2,3'd0,5'd5,7'h0B},  32'h0,         1'b1, 5'd5,  32'hA5A5_0001,  1'b0},
    '{{7'd3,5'd0,5'd1,3'd0,5'd6,7'h0B},  32'hFFFF_FFF0, 1'b1, 5'd6,  32'hFFFF_FFFF,  1'b0},
    '{{7'd3,5'd0,5'd1,3'd0,5'd7,7'h0B},  32'hFFFF_FFFF, 1'b1, 5'd7,  32'hFFFF_FFF0,  1'b0},
    '{{7'd0,5'd0,5'd2,3'd0,5'd0,7'h0B},  32'h0,         1'b0, 5'd0,  32'h0,          1'b0},
    '{{7'd5,5'd0,5'd2,3'd0,5'd8,7'h0B},  32'd100,       1'b1, 5'd8,  TCUR,           1'b1},
    '{{7'd3,5'd0,5'd1,3'd0,5'd9,7'h33},  32'h0,         1'b0, 5'd0,  32'h0,          1'b0},
    '{{7'd3,5'd0,5'd1,3'd0,5'd10,7'h0B}, 32'hFFFF_FFFF, 1'b1, 5'd10, 32'hFFFF_FFFF,  1'b0},
    '{{7'd1,5'd0,5'd4,3'd0,5'd3,7'h0B},  32'd77,        1'b0, 5'd0,  32'h0,          1'b0},
    '{{7'd0,5'd0,5'd3,3'd0,5'd31,7'h0B}, 32'h0,         1'b1, 5'd31, 32'd77,         1'b0},
    '{{7'd0,5'd0,5'd0,3'd0,5'd9,7'h0B},  32'h0,         1'b1, 5'd9,  32'h0,          1'b0}
  };

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset ready", {31'd0, ins_ready}, 32'd1);
    chk("R10 reset halt", {31'd0, halt}, 32'd0);
    chk("R5 reset redir/rd/ill/tld", {28'd0, redir_valid, rd_we, ill_flag, timer_ld}, 32'd0);

    // table walk: R1 R2 R3 R8 R11
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].w, VEC[i].rs);
      chk($sformatf("R2/R3/R8/R11 vec%0d rd_we", i), {31'd0, rd_we}, {31'd0, VEC[i].we});
      if (VEC[i].we) begin
        chk($sformatf("R2/R3/R8 vec%0d rd_idx", i), {27'd0, rd_idx}, {27'd0, VEC[i].rd});
        chk($sformatf("R2/R3/R8 vec%0d rd_val", i), rd_val, VEC[i].val);
      end
      chk($sformatf("R8 vec%0d timer_ld", i), {31'd0, timer_ld}, {31'd0, VEC[i].tld});
      if (VEC[i].tld) chk("R8 timer_ld_val", timer_ld_val, VEC[i].rs);
      chk($sformatf("R1 vec%0d no redir", i), {31'd0, redir_valid}, 32'd0);
    end

    // R4: masked request latches but does not enter
    pulse_irq(5);
    repeat (3) @(negedge clk);
    chk("R4 masked no entry", {30'd0, redir_valid, ins_ready}, 32'd1);
    issue(cw(7'd4, 5'd0, 3'd0, 5'd10), 32'h0);
    chk("R7 immediate wait rd", rd_val, 32'h20);
    chk("R7 immediate wait we", {31'd0, rd_we}, 32'd1);

    // R5: unmask bit 5, entry follows
    issue(cw(7'd3, 5'd1, 3'd0, 5'd11), ~32'h20);
    chk("R3 old mask", rd_val, 32'hFFFF_FFFF);
    chk("R12 ready low in entry cycle", {31'd0, ins_ready}, 32'd0);
    @(negedge clk);
    chk("R5 entry redir", {31'd0, redir_valid}, 32'd1);
    chk("R5 entry target", redir_pc, HPC);
    chk("R5 entry no rd", {31'd0, rd_we}, 32'd0);
    pulse_irq(5);
    repeat (2) @(negedge clk);
    chk("R5 disabled no entry", {30'd0, redir_valid, ins_ready}, 32'd1);
    issue(cw(7'd0, 5'd0, 3'd0, 5'd12), 32'h0);
    chk("R5 q0 return pc", rd_val, RPC);
    issue(cw(7'd0, 5'd1, 3'd0, 5'd13), 32'h0);
    chk("R5 q1 taken bits", rd_val, 32'h20);

    // R6: return, then immediate re-entry of the still-pending source
    issue(cw(7'd2, 5'd0, 3'd0, 5'd0), 32'h0);
    chk("R6 ret redir", {31'd0, redir_valid}, 32'd1);
    chk("R6 ret target", redir_pc, RPC);
    chk("R6 ret ready low", {31'd0, ins_ready}, 32'd0);
    @(negedge clk);
    chk("R6 re-entry target", redir_valid ? redir_pc : 32'hDEAD, HPC);
    issue(cw(7'd3, 5'd1, 3'd0, 5'd14), 32'hFFFF_FFFF);
    chk("R3 mask readback", rd_val, ~32'h20);

    // R7: sleeping wait
    issue(cw(7'd4, 5'd0, 3'd0, 5'd15), 32'h0);
    chk("R7 sleep no rd", {31'd0, rd_we}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R7 sleep ready low", {31'd0, ins_ready}, 32'd0);
    irq_req[9] = 1'b1;
    @(negedge clk);
    irq_req[9] = 1'b0;
    chk("R7 not yet written", {31'd0, rd_we}, 32'd0);
    @(negedge clk);
    chk("R7 wake rd_we", {31'd0, rd_we}, 32'd1);
    chk("R7 wake rd_idx", {27'd0, rd_idx}, 32'd15);
    chk("R7 wake rd_val", rd_val, 32'h200);
    chk("R7 wake ready", {31'd0, ins_ready}, 32'd1);

    // R9: illegal words with their source unmasked
    issue(cw(7'd3, 5'd1, 3'd0, 5'd16), ~32'h2);
    issue(cw(7'd7, 5'd0, 3'd0, 5'd3), 32'h0);
    chk("R9 funct7 illegal flag", {29'd0, ill_flag, rd_we, halt}, 32'h4);
    issue(cw(7'd0, 5'd0, 3'd1, 5'd3), 32'h0);
    chk("R9 funct3 illegal flag", {29'd0, ill_flag, rd_we, halt}, 32'h4);
    issue(cw(7'd4, 5'd0, 3'd0, 5'd17), 32'h0);
    chk("R9 pending bit1", rd_val, 32'h202);
    issue(cw(7'd3, 5'd1, 3'd0, 5'd18), 32'hFFFF_FFFF);

    // R10: bus error while masked freezes the unit
    @(negedge clk);
    bus_err = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    chk("R10 halt set", {31'd0, halt}, 32'd1);
    chk("R12 halted not ready", {31'd0, ins_ready}, 32'd0);
    ins_valid = 1'b1;
    ins_word  = cw(7'd0, 5'd0, 3'd0, 5'd20);
    repeat (2) @(negedge clk);
    ins_valid = 1'b0;
    chk("R12 halted getq ignored", {31'd0, rd_we}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R10 halt held", {31'd0, halt}, 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule